// File: doc/BRIEF.md
# SDRAM Command Timing Monitor

This block sits beside a four-bank SDRAM command bus and watches it without driving anything. On every rising clock edge it samples chip select, the three strobes, the bank select and the address. From these it works out which command was issued, keeps an open or closed flag for each bank, and counts the clocks since each bank's last activate, precharge, read and write. It also counts the clocks since the last activate and the last write on any bank. Each new command is compared against minimum spacing limits. These limits are module parameters given in clocks. The read and write recovery windows also depend on the latency and burst length that the bus last programmed through a mode-register load.

When a rule is broken, the monitor raises a violation flag and records a 4-bit reason and the bank it concerns. The flag is sticky. It keeps the first error until a synchronous clear input is asserted. Verification environments and debug logic can then tell exactly which bus command first went wrong.

Top module: `sdram_timing_monitor`

## Requirements
- R1: Commands are decoded from (ras_n, cas_n, we_n) with cs_n low: 011 activate, 101 read, 100 write, 010 precharge, 000 mode load. Any cycle with cs_n high is treated as no command and changes neither bank state nor the violation outputs.
- R2: An activate opens its bank, and a precharge closes it. A precharge with addr_i[10] high closes all banks. An activate to an open bank gives reason 1, and a read or write to a closed bank gives reason 2.
- R3: An activate that comes fewer than T_RRD clocks after an activate to a different bank gives reason 3.
- R4: A read or write to an open bank fewer than T_RCD clocks after that bank's activate gives reason 4.
- R5: A precharge of an open bank fewer than T_RAS clocks after its activate gives reason 5. A bank that is still open more than T_RAS_MAX clocks after its activate gives reason 6.
- R6: An activate to a closed bank fewer than T_RC clocks after its previous activate gives reason 7. An activate fewer than T_RP clocks after the precharge that closed the bank gives reason 8.
- R7: A precharge of an open bank fewer than CL+BL-2 clocks after a read to it gives reason 9. A mode load sets CL from addr_i[6:4], with 0 read as 1. It sets BL from addr_i[2:0]: 0 gives 1, 1 gives 2, 2 gives 4, and any other code gives 8.
- R8: A precharge of an open bank fewer than BL-1+T_WR clocks after a write to it gives reason 10. A read or write fewer than T_CDL clocks after a write to any bank gives reason 11.
- R9: The violation outputs appear on the edge that samples the offending command and then hold the first error. When errors arise in the same cycle, the smallest reason wins, and a tie goes to the lowest bank. When clr_i is high, the held error is dropped and replaced by any error found in that same cycle.
- R10: After reset, viol_o is low, all banks are closed, and CL=3 and BL=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Synchronous clear of the held violation |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write strobe, active low |
| ba_i | input | BAW (2) | Bank select |
| addr_i | input | AW (12) | Address; bit 10 selects all banks on precharge, bits 6:0 hold the mode fields |
| viol_o | output | 1 | Sticky violation flag |
| viol_code_o | output | 4 | Reason of the held violation |
| viol_bank_o | output | BAW (2) | Bank of the held violation |

## Verification
The clear input and a fresh violation can land on the same edge. The bench provokes this by holding an earlier error and then pulsing clr_i together with a read to a closed bank. It expects the reason and bank to switch to the new error rather than drop to idle, and a later clear with no error must leave the flag low. A precharge-all that breaks the active-time minimum on two banks at once is also driven, and the result is judged by the lowest bank number being reported.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_LMR,
    CMD_OTHER
  } cmd_e;

  // reason codes, smaller value wins when several arise together
  localparam logic [3:0] RSN_NONE       = 4'd0;
  localparam logic [3:0] RSN_ACT_OPEN   = 4'd1;
  localparam logic [3:0] RSN_COL_CLOSED = 4'd2;
  localparam logic [3:0] RSN_RRD        = 4'd3;
  localparam logic [3:0] RSN_RCD        = 4'd4;
  localparam logic [3:0] RSN_RAS_MIN    = 4'd5;
  localparam logic [3:0] RSN_RAS_MAX    = 4'd6;
  localparam logic [3:0] RSN_RC         = 4'd7;
  localparam logic [3:0] RSN_RP         = 4'd8;
  localparam logic [3:0] RSN_RD2PRE     = 4'd9;
  localparam logic [3:0] RSN_WR2PRE     = 4'd10;
  localparam logic [3:0] RSN_WR2COL     = 4'd11;

  function automatic logic [3:0] pick_min(input logic [3:0] a, input logic [3:0] b);
    if (a == RSN_NONE) return b;
    if (b == RSN_NONE) return a;
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cs_n_i,
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  output cmd_e cmd_o
);

  always_comb begin
    if (cs_n_i) begin
      cmd_o = CMD_NOP;
    end else begin
      unique case ({ras_n_i, cas_n_i, we_n_i})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        3'b000:  cmd_o = CMD_LMR;
        3'b111:  cmd_o = CMD_NOP;
        default: cmd_o = CMD_OTHER;
      endcase
    end
  end

endmodule

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_mon_pkg::*;
#(
  parameter int CLW = 3,
  parameter int BLW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  cmd_e           cmd_i,
  input  logic [2:0]     lat_field_i,
  input  logic [2:0]     burst_field_i,
  output logic [CLW-1:0] cl_o,
  output logic [BLW-1:0] bl_o
);

  logic [CLW-1:0] cl_q;
  logic [BLW-1:0] bl_q;
  logic [CLW-1:0] cl_d;
  logic [BLW-1:0] bl_d;

  always_comb begin
    cl_d = (lat_field_i == 3'd0) ? CLW'(1) : CLW'(lat_field_i);
    unique case (burst_field_i)
      3'd0:    bl_d = BLW'(1);
      3'd1:    bl_d = BLW'(2);
      3'd2:    bl_d = BLW'(4);
      default: bl_d = BLW'(8);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cl_q <= CLW'(3);
      bl_q <= BLW'(1);
    end else if (cmd_i == CMD_LMR) begin
      cl_q <= cl_d;
      bl_q <= bl_d;
    end
  end

  assign cl_o = cl_q;
  assign bl_o = bl_q;

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_mon_pkg::*;
#(
  parameter int CW        = 16,
  parameter int CLW       = 3,
  parameter int BLW       = 4,
  parameter int T_RCD     = 2,
  parameter int T_RAS     = 5,
  parameter int T_RAS_MAX = 12000,
  parameter int T_RC      = 7,
  parameter int T_RP      = 2,
  parameter int T_WR      = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  cmd_e           cmd_i,
  input  logic           hit_i,
  input  logic           pre_all_i,
  input  logic [CLW-1:0] cl_i,
  input  logic [BLW-1:0] bl_i,
  output logic           open_o,
  output logic [3:0]     err_o
);

  localparam logic [CW-1:0] RCD_C    = CW'(T_RCD);
  localparam logic [CW-1:0] RAS_C    = CW'(T_RAS);
  localparam logic [CW-1:0] RASMAX_C = CW'(T_RAS_MAX);
  localparam logic [CW-1:0] RC_C     = CW'(T_RC);
  localparam logic [CW-1:0] RP_C     = CW'(T_RP);

  logic          open_q;
  logic [CW-1:0] since_act, since_pre, since_rd, since_wr;
  logic          pre_me;
  int            rd_pre_lim, wr_pre_lim;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] c);
    return (&c) ? c : c + 1'b1;
  endfunction

  assign pre_me     = (cmd_i == CMD_PRE) && (hit_i || pre_all_i) && open_q;
  assign rd_pre_lim = int'(cl_i) + int'(bl_i) - 2;
  assign wr_pre_lim = int'(bl_i) - 1 + T_WR;

  always_comb begin
    err_o = RSN_NONE;
    unique case (cmd_i)
      CMD_ACT: if (hit_i) begin
        if (open_q) begin
          err_o = RSN_ACT_OPEN;
        end else begin
          if (since_act < RC_C) err_o = pick_min(err_o, RSN_RC);
          if (since_pre < RP_C) err_o = pick_min(err_o, RSN_RP);
        end
      end
      CMD_RD, CMD_WR: if (hit_i) begin
        if (!open_q)               err_o = RSN_COL_CLOSED;
        else if (since_act < RCD_C) err_o = RSN_RCD;
      end
      CMD_PRE: if (pre_me) begin
        if (since_act < RAS_C)              err_o = pick_min(err_o, RSN_RAS_MIN);
        if (int'(since_rd) < rd_pre_lim)    err_o = pick_min(err_o, RSN_RD2PRE);
        if (int'(since_wr) < wr_pre_lim)    err_o = pick_min(err_o, RSN_WR2PRE);
      end
      default: ;
    endcase
    if (open_q && (since_act > RASMAX_C)) err_o = pick_min(err_o, RSN_RAS_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      since_act <= '1;
      since_pre <= '1;
      since_rd  <= '1;
      since_wr  <= '1;
    end else begin
      since_act <= bump(since_act);
      since_pre <= bump(since_pre);
      since_rd  <= bump(since_rd);
      since_wr  <= bump(since_wr);
      if (cmd_i == CMD_ACT && hit_i) begin
        open_q    <= 1'b1;
        since_act <= CW'(1);
      end
      if (pre_me) begin
        open_q    <= 1'b0;
        since_pre <= CW'(1);
      end
      if (cmd_i == CMD_RD && hit_i) since_rd <= CW'(1);
      if (cmd_i == CMD_WR && hit_i) since_wr <= CW'(1);
    end
  end

  assign open_o = open_q;

endmodule

// File: rtl/sdram_viol_latch.sv
module sdram_viol_latch
  import sdram_mon_pkg::*;
#(
  parameter int NB  = 4,
  parameter int BAW = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic [NB-1:0][3:0]  bank_err_i,
  input  logic [3:0]          glob_err_i,
  input  logic [BAW-1:0]      glob_bank_i,
  output logic                viol_o,
  output logic [3:0]          code_o,
  output logic [BAW-1:0]      bank_o
);

  logic [3:0]     best;
  logic [BAW-1:0] best_bank;
  logic           viol_q;
  logic [3:0]     code_q;
  logic [BAW-1:0] bank_q;

  always_comb begin
    best      = RSN_NONE;
    best_bank = '0;
    for (int b = 0; b < NB; b++) begin
      logic [3:0] c;
      c = bank_err_i[b];
      if (glob_bank_i == BAW'(b)) c = pick_min(c, glob_err_i);
      if (c != RSN_NONE && (best == RSN_NONE || c < best)) begin
        best      = c;
        best_bank = BAW'(b);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_q <= 1'b0;
      code_q <= RSN_NONE;
      bank_q <= '0;
    end else if (clr_i || !viol_q) begin
      viol_q <= (best != RSN_NONE);
      code_q <= best;
      bank_q <= best_bank;
    end
  end

  assign viol_o = viol_q;
  assign code_o = code_q;
  assign bank_o = bank_q;

endmodule

// File: rtl/sdram_timing_monitor.sv
module sdram_timing_monitor
  import sdram_mon_pkg::*;
#(
  parameter int BANKS       = 4,
  parameter int AW          = 12,
  parameter int PRE_ALL_BIT = 10,
  parameter int T_RRD       = 2,
  parameter int T_RCD       = 2,
  parameter int T_RAS       = 5,
  parameter int T_RAS_MAX   = 12000,
  parameter int T_RC        = 7,
  parameter int T_RP        = 2,
  parameter int T_WR        = 2,
  parameter int T_CDL       = 1,
  localparam int BAW        = $clog2(BANKS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_i,
  input  logic           cs_n_i,
  input  logic           ras_n_i,
  input  logic           cas_n_i,
  input  logic           we_n_i,
  input  logic [BAW-1:0] ba_i,
  input  logic [AW-1:0]  addr_i,
  output logic           viol_o,
  output logic [3:0]     viol_code_o,
  output logic [BAW-1:0] viol_bank_o
);

  localparam int CW  = $clog2(T_RAS_MAX + T_RC + 64) + 1;
  localparam int CLW = 3;
  localparam int BLW = 4;
  localparam logic [CW-1:0] RRD_C = CW'(T_RRD);
  localparam logic [CW-1:0] CDL_C = CW'(T_CDL);

  cmd_e                   cmd;
  logic [CLW-1:0]         cl;
  logic [BLW-1:0]         bl;
  logic [BANKS-1:0]       open_vec;
  logic [BANKS-1:0][3:0]  bank_err;
  logic [3:0]             glob_err;
  logic [CW-1:0]          since_any_act, since_any_wr;
  logic [BAW-1:0]         last_act_bank;
  logic                   addr_unused;

  assign addr_unused = ^{addr_i[AW-1:PRE_ALL_BIT+1], addr_i[PRE_ALL_BIT-1:7], addr_i[3]};

  sdram_cmd_decode u_dec (
    .cs_n_i (cs_n_i),
    .ras_n_i(ras_n_i),
    .cas_n_i(cas_n_i),
    .we_n_i (we_n_i),
    .cmd_o  (cmd)
  );

  sdram_mode_reg #(.CLW(CLW), .BLW(BLW)) u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_i        (cmd),
    .lat_field_i  (addr_i[6:4]),
    .burst_field_i(addr_i[2:0]),
    .cl_o         (cl),
    .bl_o         (bl)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    sdram_bank_tracker #(
      .CW(CW), .CLW(CLW), .BLW(BLW),
      .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RAS_MAX(T_RAS_MAX),
      .T_RC(T_RC), .T_RP(T_RP), .T_WR(T_WR)
    ) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_i    (cmd),
      .hit_i    (ba_i == BAW'(b)),
      .pre_all_i(addr_i[PRE_ALL_BIT]),
      .cl_i     (cl),
      .bl_i     (bl),
      .open_o   (open_vec[b]),
      .err_o    (bank_err[b])
    );
  end

  // cross-bank spacing rules, charged to the commanded bank
  always_comb begin
    glob_err = RSN_NONE;
    if (cmd == CMD_ACT && since_any_act < RRD_C && last_act_bank != ba_i)
      glob_err = RSN_RRD;
    if ((cmd == CMD_RD || cmd == CMD_WR) && since_any_wr < CDL_C)
      glob_err = pick_min(glob_err, RSN_WR2COL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_any_act <= '1;
      since_any_wr  <= '1;
      last_act_bank <= '0;
    end else begin
      since_any_act <= (&since_any_act) ? since_any_act : since_any_act + 1'b1;
      since_any_wr  <= (&since_any_wr) ? since_any_wr : since_any_wr + 1'b1;
      if (cmd == CMD_ACT) begin
        since_any_act <= CW'(1);
        last_act_bank <= ba_i;
      end
      if (cmd == CMD_WR) since_any_wr <= CW'(1);
    end
  end

  sdram_viol_latch #(.NB(BANKS), .BAW(BAW)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .bank_err_i (bank_err),
    .glob_err_i (glob_err),
    .glob_bank_i(ba_i),
    .viol_o     (viol_o),
    .code_o     (viol_code_o),
    .bank_o     (viol_bank_o)
  );

endmodule

// File: rtl/sdram_mon_checks.sv
module sdram_mon_checks #(
  parameter int NB  = 4,
  parameter int BAW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           clr_i,
  input logic           cs_n,
  input logic           ras_n,
  input logic           cas_n,
  input logic           we_n,
  input logic [BAW-1:0] ba,
  input logic           pre_all,
  input logic [NB-1:0]  open_vec,
  input logic           viol,
  input logic [3:0]     code,
  input logic [BAW-1:0] bank
);

  p_code_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (code != 4'd0 && code <= 4'd11));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && !clr_i) |=> (viol && $stable(code) && $stable(bank)));

  p_deselect_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(open_vec));

  p_col_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && ras_n && !cas_n && !open_vec[ba]) |=> viol);

  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ras_n && cas_n && we_n) |=> open_vec[$past(ba)]);

  p_pre_all_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ras_n && cas_n && !we_n && pre_all) |=> (open_vec == '0));

endmodule

bind sdram_timing_monitor sdram_mon_checks #(.NB(BANKS), .BAW(BAW)) u_checks (
  .clk     (clk),
  .rst_n   (rst_n),
  .clr_i   (clr_i),
  .cs_n    (cs_n_i),
  .ras_n   (ras_n_i),
  .cas_n   (cas_n_i),
  .we_n    (we_n_i),
  .ba      (ba_i),
  .pre_all (addr_i[PRE_ALL_BIT]),
  .open_vec(open_vec),
  .viol    (viol_o),
  .code    (viol_code_o),
  .bank    (viol_bank_o)
);

// File: tb/sdram_timing_monitor_bench.sv
module sdram_timing_monitor_bench;

  localparam int RRD = 2, RCD = 3, RAS = 5, RASMAX = 40, RC = 8, RP = 3, WR = 2, CDL = 2;
  localparam logic [2:0] OP_NOP = 3'b111, OP_ACT = 3'b011, OP_RD = 3'b101,
                         OP_WR = 3'b100, OP_PRE = 3'b010, OP_LMR = 3'b000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, clr_i, cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [11:0] addr;
  logic viol;
  logic [3:0] code;
  logic [1:0] bank;
  int n_cmp = 0, n_bad = 0;

  sdram_timing_monitor #(
    .T_RRD(RRD), .T_RCD(RCD), .T_RAS(RAS), .T_RAS_MAX(RASMAX),
    .T_RC(RC), .T_RP(RP), .T_WR(WR), .T_CDL(CDL)
  ) u_sdram_timing_monitor (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .cs_n_i(cs_n), .ras_n_i(ras_n),
    .cas_n_i(cas_n), .we_n_i(we_n), .ba_i(ba), .addr_i(addr),
    .viol_o(viol), .viol_code_o(code), .viol_bank_o(bank)
  );

  task automatic drive(input logic [2:0] op, input int b, input int a, input logic clr, input logic csn);
    {ras_n, cas_n, we_n} = op;
    cs_n = csn; ba = b[1:0]; addr = a[11:0]; clr_i = clr;
    @(negedge clk);
    {ras_n, cas_n, we_n} = OP_NOP; cs_n = 1'b0; addr = '0; clr_i = 1'b0;
  endtask

  task automatic cmd(input logic [2:0] op, input int b, input int a);
    drive(op, b, a, 1'b0, 1'b0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ev, input int ec, input int eb, input string tag);
    n_cmp++;
    if (viol !== ev || (ev && (code !== ec[3:0] || bank !== eb[1:0]))) begin
      n_bad++;
      $display("FAIL %s: got viol=%0b code=%0d bank=%0d, expected viol=%0b code=%0d bank=%0d",
               tag, viol, code, bank, ev, ec, eb);
    end
  endtask

  // close every bank with generous spacing, then clear the flag
  task automatic settle();
    idle(10);
    cmd(OP_PRE, 0, 1 << 10);
    idle(10);
    drive(OP_NOP, 0, 0, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr_i = 1'b0; cs_n = 1'b1; {ras_n, cas_n, we_n} = OP_NOP; ba = '0; addr = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check(1'b0, 0, 0, "R10 reset idle");

    // R10 / R7: default CL=3 BL=1 gives read-to-precharge limit 2
    for (int d = 1; d <= 2; d++) begin
      settle();
      cmd(OP_ACT, 0, 0); idle(4); cmd(OP_RD, 0, 0); idle(d - 1); cmd(OP_PRE, 0, 0);
      check(d < 2, 9, 0, $sformatf("R10 default mode rd->pre d=%0d", d));
    end

    // R1: deselected cycles are ignored
    settle();
    drive(OP_RD, 3, 0, 1'b0, 1'b1);
    check(1'b0, 0, 0, "R1 deselected read to closed bank");
    drive(OP_ACT, 0, 0, 1'b0, 1'b1);
    idle(4);
    cmd(OP_RD, 0, 0);
    check(1'b1, 2, 0, "R1 deselected activate left bank closed");

    // R2: state rules
    settle();
    cmd(OP_ACT, 1, 0); idle(7); cmd(OP_ACT, 1, 0);
    check(1'b1, 1, 1, "R2 activate to open bank");
    settle();
    cmd(OP_ACT, 0, 0); idle(1); cmd(OP_ACT, 2, 0); idle(5); cmd(OP_PRE, 0, 0);
    cmd(OP_RD, 2, 0);
    check(1'b0, 0, 0, "R2 single precharge keeps other bank open");
    cmd(OP_RD, 0, 0);
    check(1'b1, 2, 0, "R2 read after single precharge");
    settle();
    cmd(OP_ACT, 0, 0); idle(1); cmd(OP_ACT, 2, 0); idle(5); cmd(OP_PRE, 1, 1 << 10);
    cmd(OP_RD, 2, 0);
    check(1'b1, 2, 2, "R2 read after precharge-all");

    // R3: activate-to-activate across banks
    for (int d = 1; d <= 3; d++) begin
      settle();
      cmd(OP_ACT, 0, 0); idle(d - 1); cmd(OP_ACT, 1, 0);
      check(d < RRD, 3, 1, $sformatf("R3 act->act other bank d=%0d", d));
    end

    // R4: activate to column command, read and write
    for (int d = 1; d <= 4; d++) begin
      for (int w = 0; w < 2; w++) begin
        settle();
        cmd(OP_ACT, 2, 0); idle(d - 1); cmd(w ? OP_WR : OP_RD, 2, 0);
        check(d < RCD, 4, 2, $sformatf("R4 act->col d=%0d write=%0d", d, w));
      end
    end

    // R5: minimum and maximum row-open time
    for (int d = 1; d <= 6; d++) begin
      settle();
      cmd(OP_ACT, 3, 0); idle(d - 1); cmd(OP_PRE, 3, 0);
      check(d < RAS, 5, 3, $sformatf("R5 act->pre d=%0d", d));
    end
    settle();
    cmd(OP_ACT, 0, 0); idle(RASMAX);
    check(1'b0, 0, 0, "R5 open exactly the maximum");
    idle(1);
    check(1'b1, 6, 0, "R5 open past the maximum");

    // R6: precharge time and row cycle
    for (int g = 1; g <= 4; g++) begin
      settle();
      cmd(OP_ACT, 1, 0); idle(7); cmd(OP_PRE, 1, 0); idle(g - 1); cmd(OP_ACT, 1, 0);
      check(g < RP, 8, 1, $sformatf("R6 pre->act g=%0d", g));
    end
    settle();
    cmd(OP_ACT, 1, 0); idle(1); cmd(OP_PRE, 1, 0);
    check(1'b1, 5, 1, "R6 setup early precharge");
    drive(OP_NOP, 0, 0, 1'b1, 1'b0);
    check(1'b0, 0, 0, "R9 clear with no new error");
    idle(1); cmd(OP_ACT, 1, 0);
    check(1'b1, 7, 1, "R6 row cycle too short");

    // R7: programmed latency and burst length
    cmd(OP_LMR, 0, (2 << 4) | 2);
    for (int d = 1; d <= 5; d++) begin
      settle();
      cmd(OP_ACT, 0, 0); idle(4); cmd(OP_RD, 0, 0); idle(d - 1); cmd(OP_PRE, 0, 0);
      check(d < 4, 9, 0, $sformatf("R7 CL2 BL4 rd->pre d=%0d", d));
    end
    cmd(OP_LMR, 0, (3 << 4) | 5);
    for (int d = 8; d <= 9; d++) begin
      settle();
      cmd(OP_ACT, 0, 0); idle(4); cmd(OP_RD, 0, 0); idle(d - 1); cmd(OP_PRE, 0, 0);
      check(d < 9, 9, 0, $sformatf("R7 CL3 burst code5 rd->pre d=%0d", d));
    end

    // R8: write recovery
    cmd(OP_LMR, 0, 3 << 4);
    for (int d = 1; d <= 3; d++) begin
      settle();
      cmd(OP_ACT, 1, 0); idle(4); cmd(OP_WR, 1, 0); idle(d - 1); cmd(OP_PRE, 1, 0);
      check(d < WR, 10, 1, $sformatf("R8 BL1 wr->pre d=%0d", d));
    end
    cmd(OP_LMR, 0, (3 << 4) | 2);
    for (int d = 4; d <= 5; d++) begin
      settle();
      cmd(OP_ACT, 1, 0); idle(4); cmd(OP_WR, 1, 0); idle(d - 1); cmd(OP_PRE, 1, 0);
      check(d < 5, 10, 1, $sformatf("R8 BL4 wr->pre d=%0d", d));
    end
    cmd(OP_LMR, 0, 3 << 4);
    for (int d = 1; d <= 3; d++) begin
      settle();
      cmd(OP_ACT, 1, 0); idle(4); cmd(OP_WR, 1, 0); idle(d - 1); cmd(OP_RD, 1, 0);
      check(d < CDL, 11, 1, $sformatf("R8 wr->col d=%0d", d));
    end
    settle();
    cmd(OP_ACT, 1, 0); idle(2); cmd(OP_ACT, 2, 0); idle(4); cmd(OP_WR, 1, 0); cmd(OP_RD, 2, 0);
    check(1'b1, 11, 2, "R8 wr->col across banks");

    // R9: sticky, clear together with a new error, priority across banks
    settle();
    cmd(OP_RD, 3, 0);
    check(1'b1, 2, 3, "R9 first error captured");
    idle(1); cmd(OP_RD, 1, 0);
    check(1'b1, 2, 3, "R9 later error ignored");
    drive(OP_RD, 1, 0, 1'b1, 1'b0);
    check(1'b1, 2, 1, "R9 clear with new error in same cycle");
    drive(OP_NOP, 0, 0, 1'b1, 1'b0);
    check(1'b0, 0, 0, "R9 clear alone");
    settle();
    cmd(OP_ACT, 1, 0); idle(1); cmd(OP_ACT, 2, 0); cmd(OP_PRE, 0, 1 << 10);
    check(1'b1, 5, 1, "R9 lowest bank wins on precharge-all");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule